// File: doc/BRIEF.md
# SPI Memory Slave Command Controller

This block is the serial front end of a byte-addressed nonvolatile memory. A bus master selects it by pulling the active-low chip select. The master then shifts an eight-bit command in on the serial input, most significant bit first, with any address and data bytes following. The block decodes the command. It keeps a write-enable latch and a two-bit protect field, which together form a status byte. It drives the serial output only while a read, status or identity byte is due, and holds it at high impedance at all other times.

The serial pins are sampled by the block's own system clock, so the serial clock must run several times slower than that clock. Each transaction uses SPI mode 0 or mode 3, chosen by the serial clock level at the moment chip select falls. On the storage side there is a synchronous memory port. This port provides an address, write data and a one-cycle write strobe. Read data is expected one system clock after the address. The address counter steps after every data byte and wraps within the array.

Top module: `spiMemCtl`

## Requirements
- R1: After reset the write-enable latch and the protect field are 0 (status reads 0x00), the output enable is low, the serial output is high impedance and no memory write occurs.
- R2: When chip select falls with the serial clock low the transaction runs as SPI mode 0; when it falls with the serial clock high the transaction runs as mode 3. In both modes input bits are taken on rising serial clock edges and output bits change on falling edges, and both modes give identical results.
- R3: Command 0x06 sets the write-enable latch, but only if chip select rises right after its eighth bit. Fewer or more bits leave the latch unchanged, and nothing else sets it.
- R4: Command 0x04 clears the write-enable latch, but only if chip select rises right after its eighth bit.
- R5: Command 0x05 returns the status byte repeatedly: bit 1 is the write-enable latch, bits 3..2 are the protect field, and bits 7..4 and 0 are 0.
- R6: Command 0x01 followed by a complete data byte copies data bits 3..2 into the protect field, only while the latch is 1. The data byte's other bits, including bit 1, change nothing, and an incomplete data byte commits nothing. Chip select rising after the full command byte clears the latch.
- R7: Command 0x03 takes two address bytes, high byte first. Address bits at and above the array address width are ignored. Data bytes then follow from that address upward, with the address wrapping from the top of the array to 0.
- R8: Command 0x0B behaves like 0x03 but inserts one dummy byte between the address and the first data byte.
- R9: Command 0x02 takes two address bytes. With the latch at 1, each complete data byte after them causes exactly one single-cycle memory write at a sequentially increasing, wrapping address, and a partial final byte writes nothing. With the latch at 0, nothing is written. Chip select rising after the full command byte clears the latch.
- R10: Command 0x9F returns the identity bytes, most significant byte of the identity parameter first, repeating the sequence from the start once it is exhausted.
- R11: Reserved commands (0xC3, 0xC2, 0x5A, 0x5B), the sleep command 0xB9 and every other undefined code change neither the latch, the protect field nor memory, and do not drive the serial output.
- R12: The output is driven only in the data phase of 0x05, 0x03, 0x0B and 0x9F. It is high impedance, with output enable low, whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master, high impedance when not enabled |
| soEn | output | 1 | High while the block drives `so` |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Single-cycle memory write strobe |
| memRdata | input | 8 | Memory read data, valid one clock after `memAddr` |

## Verification
Several properties are checked on every clock. The assertions confirm that the output stays disabled once chip select has been high for a few cycles, and that a memory write only happens while the write-enable latch is set. They also check that each write is a one-cycle pulse followed by an address step, that the latch only rises at the end of a transaction, and that the protect field cannot move while the latch is clear. Other behaviour can only be shown by the bench's scenarios, compared against a behavioural model. These include the exact-eight-bit rule for set and clear, the decoded status, identity and memory bytes, mode 0 against mode 3, address wrap, the dummy byte of the fast read, partial-byte aborts and the inertness of reserved codes.

// File: rtl/spiMemPkg.sv
`timescale 1ns/1ps
package spiMemPkg;
  localparam logic [7:0] OP_SET_WE   = 8'h06;
  localparam logic [7:0] OP_CLR_WE   = 8'h04;
  localparam logic [7:0] OP_RD_STAT  = 8'h05;
  localparam logic [7:0] OP_WR_STAT  = 8'h01;
  localparam logic [7:0] OP_RD_MEM   = 8'h03;
  localparam logic [7:0] OP_RD_FAST  = 8'h0B;
  localparam logic [7:0] OP_WR_MEM   = 8'h02;
  localparam logic [7:0] OP_RD_IDENT = 8'h9F;

  typedef enum logic [1:0] {
    SRC_STATUS = 2'd0,
    SRC_IDENT  = 2'd1,
    SRC_MEM    = 2'd2
  } outSrc_e;

  typedef struct packed {
    logic    shiftIn;
    logic    capHi;
    logic    capLo;
    logic    wrMem;
    logic    loadOut;
    logic    shiftOut;
    logic    soOff;
    outSrc_e src;
  } dpStrb_t;
endpackage

// File: rtl/spiMemPinSync.sv
`timescale 1ns/1ps
module spiMemPinSync (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output logic csFallE,
  output logic csRiseE,
  output logic sckRiseE,
  output logic sckFallE,
  output logic siS,
  output logic mode3
);
  logic csQ, csP, sckQ, sckP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ   <= 1'b1;
      csP   <= 1'b1;
      sckQ  <= 1'b0;
      sckP  <= 1'b0;
      siS   <= 1'b0;
      mode3 <= 1'b0;
    end else begin
      csQ  <= csN;
      csP  <= csQ;
      sckQ <= sck;
      sckP <= sckQ;
      siS  <= si;
      if (csFallE) mode3 <= sckQ;
    end
  end

  assign csFallE  = csP & ~csQ;
  assign csRiseE  = ~csP & csQ;
  assign sckRiseE = ~csQ & sckQ & ~sckP;
  assign sckFallE = ~csQ & ~sckQ & sckP;
endmodule

// File: rtl/spiMemCtrl.sv
`timescale 1ns/1ps
module spiMemCtrl
  import spiMemPkg::*;
#(
  parameter int ID_BYTES = 3,
  parameter logic [8*ID_BYTES-1:0] ID_VAL = 24'hA13C07
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csFallE,
  input  logic        csRiseE,
  input  logic        sckRiseE,
  input  logic        sckFallE,
  input  logic        mode3,
  input  logic [7:0]  rxByte,
  output dpStrb_t     strb,
  output logic [7:0]  statusByte,
  output logic [7:0]  idByte
);
  localparam int ID_IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  logic [2:0]          bitIdx, byteIdx;
  logic [7:0]          opQ;
  logic                opValid, seenRise, welQ;
  logic [1:0]          bpQ;
  logic [ID_IDX_W-1:0] idIdx;

  logic [7:0] idTab [ID_BYTES];
  for (genvar g = 0; g < ID_BYTES; g++) begin : gIdTab
    assign idTab[g] = ID_VAL[8*(ID_BYTES-1-g) +: 8];
  end
  assign idByte = idTab[idIdx];

  assign statusByte = {4'b0000, bpQ, welQ, 1'b0};

  logic       isAddrOp, outOp;
  logic [2:0] outStart;
  outSrc_e    srcSel;

  always_comb begin
    isAddrOp = 1'b0;
    outOp    = 1'b0;
    outStart = 3'd7;
    srcSel   = SRC_MEM;
    case (opQ)
      OP_RD_STAT:  begin outOp = 1'b1; outStart = 3'd1; srcSel = SRC_STATUS; end
      OP_RD_IDENT: begin outOp = 1'b1; outStart = 3'd1; srcSel = SRC_IDENT; end
      OP_RD_MEM:   begin isAddrOp = 1'b1; outOp = 1'b1; outStart = 3'd3; end
      OP_RD_FAST:  begin isAddrOp = 1'b1; outOp = 1'b1; outStart = 3'd4; end
      OP_WR_MEM:   isAddrOp = 1'b1;
      default:     ;
    endcase
  end

  logic byteDone, exact8, fallOk, inOutPhase;
  assign byteDone   = sckRiseE && (bitIdx == 3'd7);
  assign exact8     = (byteIdx == 3'd1) && (bitIdx == 3'd0);
  assign fallOk     = !mode3 || seenRise;
  assign inOutPhase = opValid && outOp && (byteIdx >= outStart);

  always_comb begin
    strb          = '0;
    strb.src      = srcSel;
    strb.shiftIn  = sckRiseE;
    strb.capHi    = byteDone && opValid && isAddrOp && (byteIdx == 3'd1);
    strb.capLo    = byteDone && opValid && isAddrOp && (byteIdx == 3'd2);
    strb.wrMem    = byteDone && opValid && (opQ == OP_WR_MEM) && (byteIdx >= 3'd3) && welQ;
    strb.loadOut  = sckFallE && fallOk && inOutPhase && (bitIdx == 3'd0);
    strb.shiftOut = sckFallE && fallOk && inOutPhase && (bitIdx != 3'd0);
    strb.soOff    = csRiseE || csFallE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx   <= '0;
      byteIdx  <= '0;
      opQ      <= '0;
      opValid  <= 1'b0;
      seenRise <= 1'b0;
      welQ     <= 1'b0;
      bpQ      <= '0;
      idIdx    <= '0;
    end else begin
      if (csFallE) begin
        bitIdx   <= '0;
        byteIdx  <= '0;
        opValid  <= 1'b0;
        seenRise <= 1'b0;
        idIdx    <= '0;
      end else if (sckRiseE) begin
        bitIdx   <= bitIdx + 3'd1;
        seenRise <= 1'b1;
        if (byteDone) begin
          if (byteIdx != 3'd7) byteIdx <= byteIdx + 3'd1;
          if (byteIdx == 3'd0) begin
            opQ     <= rxByte;
            opValid <= 1'b1;
          end
          if (opValid && (opQ == OP_WR_STAT) && (byteIdx == 3'd1) && welQ)
            bpQ <= rxByte[3:2];
        end
      end
      if (strb.loadOut && (srcSel == SRC_IDENT))
        idIdx <= (idIdx == ID_IDX_W'(ID_BYTES - 1)) ? '0 : idIdx + ID_IDX_W'(1);
      if (csRiseE && opValid) begin
        case (opQ)
          OP_SET_WE: if (exact8) welQ <= 1'b1;
          OP_CLR_WE: if (exact8) welQ <= 1'b0;
          OP_WR_STAT, OP_WR_MEM: welQ <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spiMemDp.sv
`timescale 1ns/1ps
module spiMemDp
  import spiMemPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic              siS,
  input  logic [7:0]        statusByte,
  input  logic [7:0]        idByte,
  input  logic [7:0]        memRdata,
  output logic [7:0]        rxByte,
  output logic              soBit,
  output logic              soEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe
);
  logic [7:0]        shIn, shOut, hiQ, txSel;
  logic [ADDR_W-1:0] addrQ;

  assign rxByte  = {shIn[6:0], siS};
  assign soBit   = shOut[7];
  assign memAddr = addrQ;

  always_comb begin
    case (strb.src)
      SRC_STATUS: txSel = statusByte;
      SRC_IDENT:  txSel = idByte;
      default:    txSel = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn     <= '0;
      shOut    <= '0;
      hiQ      <= '0;
      addrQ    <= '0;
      memWe    <= 1'b0;
      memWdata <= '0;
      soEn     <= 1'b0;
    end else begin
      if (strb.shiftIn) shIn <= rxByte;
      if (strb.capHi)   hiQ  <= rxByte;
      if (strb.capLo)   addrQ <= ADDR_W'({hiQ, rxByte});
      memWe <= strb.wrMem;
      if (strb.wrMem) memWdata <= rxByte;
      if (memWe) addrQ <= addrQ + ADDR_W'(1);
      if (strb.loadOut) begin
        shOut <= txSel;
        soEn  <= 1'b1;
        if (strb.src == SRC_MEM) addrQ <= addrQ + ADDR_W'(1);
      end else if (strb.shiftOut) begin
        shOut <= {shOut[6:0], 1'b0};
      end
      if (strb.soOff) soEn <= 1'b0;
    end
  end
endmodule

// File: rtl/spiMemCtl.sv
`timescale 1ns/1ps
module spiMemCtl
  import spiMemPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ID_BYTES = 3,
  parameter logic [8*ID_BYTES-1:0] ID_VAL = 24'hA13C07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              soEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata
);
  logic       csFallE, csRiseE, sckRiseE, sckFallE, siS, mode3, soBit;
  logic [7:0] rxByte, statusByte, idByte;
  dpStrb_t    strb;

  spiMemPinSync uSync (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .csFallE(csFallE), .csRiseE(csRiseE), .sckRiseE(sckRiseE),
    .sckFallE(sckFallE), .siS(siS), .mode3(mode3)
  );

  spiMemCtrl #(.ID_BYTES(ID_BYTES), .ID_VAL(ID_VAL)) uCtrl (
    .clk(clk), .rstN(rstN), .csFallE(csFallE), .csRiseE(csRiseE),
    .sckRiseE(sckRiseE), .sckFallE(sckFallE), .mode3(mode3),
    .rxByte(rxByte), .strb(strb), .statusByte(statusByte), .idByte(idByte)
  );

  spiMemDp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .siS(siS),
    .statusByte(statusByte), .idByte(idByte), .memRdata(memRdata),
    .rxByte(rxByte), .soBit(soBit), .soEn(soEn), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe)
  );

  assign so = soEn ? soBit : 1'bz;
endmodule

// File: rtl/spiMemChk.sv
`timescale 1ns/1ps
module spiMemChk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              soEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        statusByte
);
  AST_SO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !soEn); // R12

  AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> statusByte[1]); // R9

  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R9

  AST_WE_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (memAddr == $past(memAddr) + ADDR_W'(1))); // R7

  AST_WEL_RISE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[1]) |-> $past(csN)); // R3

  AST_BP_HELD_NO_WEL: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[1] |=> $stable(statusByte[3:2])); // R6
endmodule

bind spiMemCtl spiMemChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .soEn(soEn), .memWe(memWe),
  .memAddr(memAddr), .statusByte(statusByte)
);

// File: tb/spiMemCtl_tb.sv
`timescale 1ns/1ps
module spiMemCtl_tb_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1;
  logic          sck = 1'b0;
  logic          si = 1'b0;
  wire           so;
  logic          soEn;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata, memRdata;
  logic          memWe;

  always #2.5 clk = ~clk;

  spiMemCtl #(.ADDR_W(AW), .ID_BYTES(3), .ID_VAL(24'hA13C07)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .so(so),
    .soEn(soEn), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata)
  );

  // Storage array attached to the memory port
  logic [7:0] mem [DEPTH];
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] txb [16];
  logic [7:0] rxb [16];
  bit         drvAll [16];
  bit         drvAny [16];

  // Behavioural reference model
  bit         mWel = 1'b0;
  logic [1:0] mBp = 2'b00;
  logic [7:0] mMem [DEPTH];
  logic [7:0] expB [16];
  bit         expDrv [16];
  int         expWe = 0, dutWe = 0;
  logic [7:0] idv [3] = '{8'hA1, 8'h3C, 8'h07};

  // Per-clock monitors
  int idleCnt = 0, idleErr = 0, zErr = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) dutWe++;
      if (csN) idleCnt++; else idleCnt = 0;
      if (idleCnt >= 4 && (soEn || so !== 1'bz)) idleErr++;
      if (!soEn && so !== 1'bz) zErr++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clrTx();
    for (int i = 0; i < 16; i++) txb[i] = 8'h00;
  endtask

  task automatic modelStep(input int nbits);
    int nFull;
    logic [7:0] opc;
    logic [AW-1:0] a;
    nFull = nbits / 8;
    opc = txb[0];
    a = AW'({txb[1], txb[2]});
    for (int i = 0; i < 16; i++) begin expDrv[i] = 1'b0; expB[i] = 8'h00; end
    if (nbits >= 8) begin
      case (opc)
        8'h05: for (int i = 1; i < nFull; i++) begin
                 expDrv[i] = 1'b1; expB[i] = {4'b0000, mBp, mWel, 1'b0};
               end
        8'h9F: for (int i = 1; i < nFull; i++) begin
                 expDrv[i] = 1'b1; expB[i] = idv[(i - 1) % 3];
               end
        8'h03: for (int i = 3; i < nFull; i++) begin
                 expDrv[i] = 1'b1; expB[i] = mMem[a + AW'(i - 3)];
               end
        8'h0B: for (int i = 4; i < nFull; i++) begin
                 expDrv[i] = 1'b1; expB[i] = mMem[a + AW'(i - 4)];
               end
        8'h01: begin
                 if (nFull >= 2 && mWel) mBp = txb[1][3:2];
                 mWel = 1'b0;
               end
        8'h02: begin
                 if (mWel)
                   for (int i = 3; i < nFull; i++) begin
                     mMem[a + AW'(i - 3)] = txb[i];
                     expWe++;
                   end
                 mWel = 1'b0;
               end
        8'h06: if (nbits == 8) mWel = 1'b1;
        8'h04: if (nbits == 8) mWel = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic drive(input bit m3, input int nbits);
    for (int i = 0; i < 16; i++) begin drvAll[i] = 1'b1; drvAny[i] = 1'b0; rxb[i] = 8'h00; end
    sck = m3;
    repeat (6) @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      int i, k;
      i = b / 8;
      k = 7 - (b % 8);
      if (m3) sck = 1'b0;
      si = txb[i][k];
      repeat (4) @(negedge clk);
      rxb[i][k] = so;
      drvAll[i] = drvAll[i] & soEn;
      drvAny[i] = drvAny[i] | soEn;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      if (!m3) sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic run(input string req, input bit m3, input int nbits);
    int nFull;
    bit stray;
    nFull = nbits / 8;
    stray = 1'b0;
    modelStep(nbits);
    drive(m3, nbits);
    for (int i = 0; i < 16; i++) begin
      if (i < nFull && expDrv[i])
        chk(drvAll[i] && rxb[i] === expB[i], req, "output byte",
            {23'b0, drvAll[i], rxb[i]}, {23'b0, 1'b1, expB[i]});
      else if (drvAny[i])
        stray = 1'b1;
    end
    chk(!stray, req, "output driven outside data phase", stray, 0);
  endtask

  task automatic cmd(input string req, input bit m3, input logic [7:0] o, input int nbits);
    clrTx();
    txb[0] = o;
    run(req, m3, nbits);
  endtask

  task automatic rdsr(input string req, input bit m3, input logic [7:0] expv);
    clrTx();
    txb[0] = 8'h05;
    run(req, m3, 24);
    chk(rxb[1] === expv && rxb[2] === expv, req, "status value", rxb[1], expv);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]  = 8'((i * 7 + 3) & 8'hFF);
      mMem[i] = 8'((i * 7 + 3) & 8'hFF);
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(soEn == 1'b0 && so === 1'bz, "R1", "output after reset", {soEn, so}, 0);
    chk(memWe == 1'b0, "R1", "write strobe after reset", memWe, 0);
    rdsr("R1 R5", 1'b0, 8'h00);

    // R6 status write without latch
    clrTx(); txb[0] = 8'h01; txb[1] = 8'hFF; run("R6", 1'b1, 16);
    rdsr("R6", 1'b1, 8'h00);

    // R3 wrong lengths, then exact length in mode 3
    cmd("R3", 1'b0, 8'h06, 9);
    rdsr("R3", 1'b0, 8'h00);
    cmd("R3", 1'b0, 8'h06, 7);
    rdsr("R3", 1'b0, 8'h00);
    cmd("R3 R2", 1'b1, 8'h06, 8);
    rdsr("R3 R2 R5", 1'b1, 8'h02);

    // R6 protect field write, latch cleared, data bit 1 ignored
    clrTx(); txb[0] = 8'h01; txb[1] = 8'h0D; run("R6", 1'b0, 16);
    rdsr("R6", 1'b0, 8'h0C);

    // R4 clear latch only with exact length
    cmd("R3", 1'b0, 8'h06, 8);
    cmd("R4", 1'b1, 8'h04, 16);
    rdsr("R4", 1'b0, 8'h0E);
    cmd("R4", 1'b0, 8'h04, 8);
    rdsr("R4", 1'b1, 8'h0C);

    // R6 incomplete data byte commits nothing
    cmd("R3", 1'b0, 8'h06, 8);
    clrTx(); txb[0] = 8'h01; txb[1] = 8'h00; run("R6", 1'b1, 12);
    rdsr("R6", 1'b0, 8'h0C);

    // R6 data byte cannot set the latch
    cmd("R3", 1'b1, 8'h06, 8);
    clrTx(); txb[0] = 8'h01; txb[1] = 8'hF2; run("R6", 1'b0, 16);
    rdsr("R6", 1'b0, 8'h00);

    // R9 write without latch
    clrTx(); txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h10;
    txb[3] = 8'h99; txb[4] = 8'h98; txb[5] = 8'h97;
    run("R9", 1'b0, 48);
    chk(dutWe == 0, "R9", "writes without latch", dutWe, 0);

    // R9 write with latch and partial trailing byte
    cmd("R3", 1'b0, 8'h06, 8);
    clrTx(); txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h10;
    txb[3] = 8'hA5; txb[4] = 8'h3C; txb[5] = 8'h7E; txb[6] = 8'hFF;
    run("R9", 1'b1, 53);
    chk(dutWe == 3, "R9", "write count", dutWe, 3);
    rdsr("R9", 1'b0, 8'h00);

    // R7 read back in both modes
    clrTx(); txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = 8'h10; run("R7 R2", 1'b1, 56);
    chk(rxb[3] === 8'hA5 && rxb[5] === 8'h7E, "R7", "read data", {rxb[3], rxb[5]}, 16'hA57E);
    clrTx(); txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = 8'h10; run("R7 R2", 1'b0, 56);

    // R9 R7 wrap: high address bits ignored
    cmd("R3", 1'b1, 8'h06, 8);
    clrTx(); txb[0] = 8'h02; txb[1] = 8'hFF; txb[2] = 8'hFE;
    txb[3] = 8'h11; txb[4] = 8'h22; txb[5] = 8'h33;
    run("R9", 1'b0, 48);
    clrTx(); txb[0] = 8'h03; txb[1] = 8'h03; txb[2] = 8'hFE; run("R7", 1'b0, 48);
    chk(rxb[5] === 8'h33, "R7", "wrapped read", rxb[5], 8'h33);

    // R8 fast read with dummy byte
    clrTx(); txb[0] = 8'h0B; txb[1] = 8'h03; txb[2] = 8'hFF; run("R8", 1'b0, 48);
    chk(rxb[4] === 8'h22 && rxb[5] === 8'h33, "R8", "fast read data", {rxb[4], rxb[5]}, 16'h2233);
    clrTx(); txb[0] = 8'h0B; txb[1] = 8'h00; txb[2] = 8'h11; run("R8 R2", 1'b1, 48);

    // R10 identity sequence with repeat
    cmd("R10", 1'b0, 8'h9F, 48);
    chk(rxb[1] === 8'hA1 && rxb[4] === 8'hA1 && rxb[5] === 8'h3C, "R10", "identity repeat",
        {rxb[1], rxb[4], rxb[5]}, 24'hA1A13C);
    cmd("R10 R2", 1'b1, 8'h9F, 32);

    // R11 reserved and undefined codes
    cmd("R3", 1'b0, 8'h06, 8);
    cmd("R11", 1'b0, 8'hC3, 16);
    cmd("R11", 1'b1, 8'h5A, 8);
    cmd("R11", 1'b0, 8'hB9, 8);
    clrTx(); txb[0] = 8'h5B; txb[1] = 8'h01; txb[2] = 8'hFF; run("R11", 1'b1, 24);
    cmd("R11", 1'b0, 8'hC2, 24);
    rdsr("R11", 1'b0, 8'h02);
    cmd("R4", 1'b1, 8'h04, 8);
    rdsr("R4", 1'b1, 8'h00);

    // Final comparisons
    chk(dutWe == expWe, "R9", "total writes", dutWe, expWe);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] !== mMem[i]) bad++;
      chk(bad == 0, "R9", "array mismatches", bad, 0);
    end
    chk(idleErr == 0, "R12", "driven while deselected", idleErr, 0);
    chk(zErr == 0, "R12", "output not high impedance when disabled", zErr, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule